// File: doc/BRIEF.md
# Interrupt Pending and Wakeup Controller

This block gathers interrupt requests for a small microcontroller core and hands the most urgent one to the CPU. Four external pins, a nonmaskable input, eleven internal peripheral lines and four capture-overrun events are watched for rising edges. Each edge is latched into a pending bit. A mask bit gates each maskable source. A fixed-priority encoder then presents a valid flag and a 5-bit source index. When the CPU acknowledges, the presented pending bit is cleared and the next candidate appears on the following clock edge.

Software reaches the pending and mask state through a byte-wide register port. The 16 maskable pending bits and their mask bits sit in low and high byte banks. The four overrun events have their own pending and mask bytes. The masked overrun bits are ORed, and a rise of that OR sets main pending bit 0.

A wakeup path watches the power mode. In idle, any enabled pending request wakes the core. In standby and powerdown, a high level on an external pin whose special-function-input flag is set wakes the core whatever that pin's mask bit holds. A second output then tells the core whether to enter the service routine or to resume after the sleep instruction.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, every pending register, mask register, overrun pending register and overrun mask register reads 0, and `irq_valid`, `wake` and `wake_isr` are 0.
- R2: A rising edge on `ext_irq[j]` sets pending bit 12+j. In run and idle modes (`pwr_mode` 0 and 1), the pins are sampled only on cycles with `sample_en` high, so a pulse that never coincides with `sample_en` is lost. In standby (2) and powerdown (3), the pins are sampled every cycle.
- R3: A rising edge on `periph_irq[i]` sets pending bit i+1. A rising edge on `ovr_evt[k]` sets overrun pending bit k. A rise of the OR of (overrun pending AND overrun mask) sets pending bit 0.
- R4: The register port has a combinational read and a write that takes effect at the clock edge. The addresses are: 0 = pending bits 7:0, 1 = pending bits 15:8, 2 = mask bits 7:0, 3 = mask bits 15:8, 4 = overrun pending in bits 3:0, 5 = overrun mask in bits 3:0. Unused bits and addresses 6 and 7 read 0.
- R5: A rising edge on `nmi` is sampled under the same rule as R2. It latches a nonmaskable pending flag, which is presented as index 31 ahead of every other source and regardless of any mask bit.
- R6: With no nonmaskable request pending, `irq_idx` is the highest bit index whose pending and mask bits are both 1, and `irq_valid` is 1. If no such bit exists, `irq_valid` is 0. A pending bit whose mask bit is 0 is never presented.
- R7: Driving `ack` while `irq_valid` is 1 clears the pending bit of the presented index (or the nonmaskable flag for index 31). `irq_valid` and `irq_idx` show the next candidate right after that same clock edge.
- R8: If hardware sets a pending bit in the same cycle that software writes 0 to it, the bit ends up 1.
- R9: In standby or powerdown, `wake` rises when any external pin with its `ext_sfi` bit set is high, independent of masks. `wake_isr` is 1 only if such a pin also has its mask bit set.
- R10: In idle, `wake` and `wake_isr` are 1 while any pending bit has its mask bit set or the nonmaskable flag is pending. Masked-off pending bits do not wake the core.
- R11: In run mode, `wake` and `wake_isr` are 0 one cycle later. `wake_isr` is never 1 without `wake`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Pin sampling strobe (clock phase two) in run and idle |
| pwr_mode | input | 2 | 0 run, 1 idle, 2 standby, 3 powerdown |
| ext_irq | input | 4 | External interrupt pins |
| ext_sfi | input | 4 | Per-pin special-function-input configuration |
| nmi | input | 1 | Nonmaskable interrupt input |
| periph_irq | input | 11 | Internal peripheral request lines |
| ovr_evt | input | 4 | Capture-overrun event lines |
| ack | input | 1 | Acknowledge of the presented request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_valid | output | 1 | A request is presented |
| irq_idx | output | 5 | Index of the presented request |
| wake | output | 1 | Leave the power-saving mode |
| wake_isr | output | 1 | After waking, enter the service routine |

## Verification
On every cycle, the assertions check the following. A pending nonmaskable request owns the output, and any other presented index is both pending and enabled. An acknowledge removes its bit unless hardware sets it again. Hardware sets survive concurrent writes. Run mode keeps the wake outputs low, and `wake_isr` never stands alone. Only the bench scenarios can show the rest: the strobe gating of the pins, the overrun aggregation chain, the exact priority order, the register map, and the mode-dependent wake decision under different mask and configuration settings.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int SRC_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int NUM_EXT    = 4;
  localparam int NUM_OVR    = 4;
  localparam int NUM_PERIPH = SRC_W - 1 - NUM_EXT;
  localparam int IDX_W      = 5;
  localparam int SRC_IDX_W  = $clog2(SRC_W);
  localparam int OVR_BIT    = 0;
  localparam int PER_BASE   = 1;
  localparam int EXT_BASE   = PER_BASE + NUM_PERIPH;
  localparam int ADDR_W     = 3;
  localparam logic [IDX_W-1:0] NMI_IDX = '1;

  typedef enum logic [1:0] {
    PM_RUN  = 2'd0,
    PM_IDLE = 2'd1,
    PM_STBY = 2'd2,
    PM_PDN  = 2'd3
  } pmode_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_PEND_LO  = 3'd0,
    RA_PEND_HI  = 3'd1,
    RA_MASK_LO  = 3'd2,
    RA_MASK_HI  = 3'd3,
    RA_OVR_PEND = 3'd4,
    RA_OVR_MASK = 3'd5
  } raddr_e;
endpackage

// File: rtl/irq_edge_cap.sv
module irq_edge_cap #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise
);
  logic [W-1:0] smp_q;
  logic [W-1:0] smp_n;

  always_comb begin
    smp_n = smp_q;
    rise  = '0;
    if (strobe) begin
      smp_n = din;
      rise  = din & ~smp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp_n;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc
  import irq_pkg::*;
#(
  parameter int W = SRC_W
) (
  input  logic [W-1:0]     req,
  input  logic             nmi_req,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = 0; i < W; i++) begin
      if (req[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    if (nmi_req) begin
      valid = 1'b1;
      idx   = NMI_IDX;
    end
  end
endmodule

// File: rtl/irq_wake.sv
module irq_wake
  import irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic [NUM_EXT-1:0] pin,
  input  logic [NUM_EXT-1:0] sfi,
  input  logic [NUM_EXT-1:0] pin_en,
  input  logic               idle_hit,
  output logic               wake,
  output logic               wake_isr
);
  logic [NUM_EXT-1:0] pin_q;
  logic [NUM_EXT-1:0] sfi_hit;
  logic               wake_n, isr_n, wake_q, isr_q;
  pmode_e             pm;

  assign pm      = pmode_e'(mode);
  assign sfi_hit = pin_q & sfi;

  always_comb begin
    wake_n = 1'b0;
    isr_n  = 1'b0;
    case (pm)
      PM_IDLE: begin
        wake_n = idle_hit;
        isr_n  = idle_hit;
      end
      PM_STBY, PM_PDN: begin
        wake_n = |sfi_hit;
        isr_n  = |(sfi_hit & pin_en);
      end
      default: begin
        wake_n = 1'b0;
        isr_n  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q  <= '0;
      wake_q <= 1'b0;
      isr_q  <= 1'b0;
    end else begin
      pin_q  <= pin;
      wake_q <= wake_n;
      isr_q  <= isr_n;
    end
  end

  assign wake     = wake_q;
  assign wake_isr = isr_q;

  a_r11_isr_needs_wake: assert property (@(posedge clk) disable iff (!rst_n)
    wake_isr |-> wake) else $error("R11 wake_isr without wake");

  a_r11_run_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == PM_RUN) |=> (!wake && !wake_isr)) else $error("R11 wake in run mode");
endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
  import irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sample_en,
  input  logic [1:0]            pwr_mode,
  input  logic [NUM_EXT-1:0]    ext_irq,
  input  logic [NUM_EXT-1:0]    ext_sfi,
  input  logic                  nmi,
  input  logic [NUM_PERIPH-1:0] periph_irq,
  input  logic [NUM_OVR-1:0]    ovr_evt,
  input  logic                  ack,
  input  logic                  reg_wr,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [BYTE_W-1:0]     reg_wdata,
  output logic [BYTE_W-1:0]     reg_rdata,
  output logic                  irq_valid,
  output logic [IDX_W-1:0]      irq_idx,
  output logic                  wake,
  output logic                  wake_isr
);
  pmode_e pm;
  logic   pin_strobe;

  logic [NUM_EXT-1:0]    ext_rise;
  logic                  nmi_rise;
  logic [NUM_PERIPH-1:0] per_rise;
  logic [NUM_OVR-1:0]    ovr_rise;
  logic                  agg_rise;
  logic                  ovr_agg;

  logic [SRC_W-1:0]   pend_q, pend_n, mask_q, mask_n, set_vec, ack_vec, pend_base;
  logic [NUM_OVR-1:0] ovr_pend_q, ovr_pend_n, ovr_mask_q, ovr_mask_n;
  logic               nmi_pend_q, nmi_pend_n;
  logic               ack_hit, ack_nmi;
  logic               wr_pl, wr_ph, wr_ml, wr_mh, wr_op, wr_om;

  logic               irq_valid_q, enc_valid;
  logic [IDX_W-1:0]   irq_idx_q, enc_idx;

  assign pm         = pmode_e'(pwr_mode);
  assign pin_strobe = sample_en | (pm == PM_STBY) | (pm == PM_PDN);

  irq_edge_cap #(.W(NUM_EXT)) u_ext (
    .clk(clk), .rst_n(rst_n), .strobe(pin_strobe), .din(ext_irq), .rise(ext_rise));
  irq_edge_cap #(.W(1)) u_nmi (
    .clk(clk), .rst_n(rst_n), .strobe(pin_strobe), .din(nmi), .rise(nmi_rise));
  irq_edge_cap #(.W(NUM_PERIPH)) u_per (
    .clk(clk), .rst_n(rst_n), .strobe(1'b1), .din(periph_irq), .rise(per_rise));
  irq_edge_cap #(.W(NUM_OVR)) u_ovr (
    .clk(clk), .rst_n(rst_n), .strobe(1'b1), .din(ovr_evt), .rise(ovr_rise));
  irq_edge_cap #(.W(1)) u_agg (
    .clk(clk), .rst_n(rst_n), .strobe(1'b1), .din(ovr_agg), .rise(agg_rise));

  assign ovr_agg = |(ovr_pend_q & ovr_mask_q);

  always_comb begin
    set_vec                            = '0;
    set_vec[OVR_BIT]                   = agg_rise;
    set_vec[PER_BASE +: NUM_PERIPH]    = per_rise;
    set_vec[EXT_BASE +: NUM_EXT]       = ext_rise;
  end

  // register write decode
  always_comb begin
    wr_pl = reg_wr && (reg_addr == RA_PEND_LO);
    wr_ph = reg_wr && (reg_addr == RA_PEND_HI);
    wr_ml = reg_wr && (reg_addr == RA_MASK_LO);
    wr_mh = reg_wr && (reg_addr == RA_MASK_HI);
    wr_op = reg_wr && (reg_addr == RA_OVR_PEND);
    wr_om = reg_wr && (reg_addr == RA_OVR_MASK);
  end

  // acknowledge decode
  always_comb begin
    ack_hit = ack && irq_valid_q;
    ack_nmi = ack_hit && (irq_idx_q == NMI_IDX);
    ack_vec = '0;
    if (ack_hit && !ack_nmi) ack_vec = SRC_W'(1) << irq_idx_q[SRC_IDX_W-1:0];
  end

  // next-state: software write, then ack clear, then hardware set (set wins)
  always_comb begin
    pend_base = pend_q;
    if (wr_pl) pend_base[BYTE_W-1:0]      = reg_wdata;
    if (wr_ph) pend_base[SRC_W-1:BYTE_W]  = reg_wdata;
    pend_n = (pend_base & ~ack_vec) | set_vec;

    mask_n = mask_q;
    if (wr_ml) mask_n[BYTE_W-1:0]     = reg_wdata;
    if (wr_mh) mask_n[SRC_W-1:BYTE_W] = reg_wdata;

    ovr_pend_n = (wr_op ? reg_wdata[NUM_OVR-1:0] : ovr_pend_q) | ovr_rise;
    ovr_mask_n = wr_om ? reg_wdata[NUM_OVR-1:0] : ovr_mask_q;

    nmi_pend_n = (nmi_pend_q & ~ack_nmi) | nmi_rise;
  end

  irq_prio_enc #(.W(SRC_W)) u_enc (
    .req(pend_n & mask_n), .nmi_req(nmi_pend_n), .valid(enc_valid), .idx(enc_idx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= '0;
      mask_q      <= '0;
      ovr_pend_q  <= '0;
      ovr_mask_q  <= '0;
      nmi_pend_q  <= 1'b0;
      irq_valid_q <= 1'b0;
      irq_idx_q   <= '0;
    end else begin
      pend_q      <= pend_n;
      mask_q      <= mask_n;
      ovr_pend_q  <= ovr_pend_n;
      ovr_mask_q  <= ovr_mask_n;
      nmi_pend_q  <= nmi_pend_n;
      irq_valid_q <= enc_valid;
      irq_idx_q   <= enc_idx;
    end
  end

  // register read
  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_PEND_LO:  reg_rdata = pend_q[BYTE_W-1:0];
      RA_PEND_HI:  reg_rdata = pend_q[SRC_W-1:BYTE_W];
      RA_MASK_LO:  reg_rdata = mask_q[BYTE_W-1:0];
      RA_MASK_HI:  reg_rdata = mask_q[SRC_W-1:BYTE_W];
      RA_OVR_PEND: reg_rdata[NUM_OVR-1:0] = ovr_pend_q;
      RA_OVR_MASK: reg_rdata[NUM_OVR-1:0] = ovr_mask_q;
      default:     reg_rdata = '0;
    endcase
  end

  irq_wake u_wake (
    .clk(clk), .rst_n(rst_n), .mode(pwr_mode), .pin(ext_irq), .sfi(ext_sfi),
    .pin_en(mask_q[EXT_BASE +: NUM_EXT]),
    .idle_hit((|(pend_q & mask_q)) | nmi_pend_q),
    .wake(wake), .wake_isr(wake_isr));

  assign irq_valid = irq_valid_q;
  assign irq_idx   = irq_idx_q;

  a_r5_nmi_first: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pend_q |-> (irq_valid_q && irq_idx_q == NMI_IDX))
    else $error("R5 nmi not presented");

  a_r6_idx_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_q && irq_idx_q != NMI_IDX) |->
      (pend_q[irq_idx_q[SRC_IDX_W-1:0]] && mask_q[irq_idx_q[SRC_IDX_W-1:0]]))
    else $error("R6 presented index not pending and enabled");

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && irq_valid_q && irq_idx_q != NMI_IDX && !reg_wr &&
     !set_vec[irq_idx_q[SRC_IDX_W-1:0]])
      |=> !pend_q[$past(irq_idx_q[SRC_IDX_W-1:0])])
    else $error("R7 ack did not clear");

  a_r8_hw_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((pend_q & $past(set_vec)) == $past(set_vec)))
    else $error("R8 hardware set lost");
endmodule

// File: tb/irq_pend_ctrl_bench.sv
module irq_pend_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_en;
  logic [1:0]  pwr_mode;
  logic [3:0]  ext_irq, ext_sfi, ovr_evt;
  logic        nmi, ack, reg_wr;
  logic [10:0] periph_irq;
  logic [2:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic        irq_valid, wake, wake_isr;
  logic [4:0]  irq_idx;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  irq_pend_ctrl u_irq_pend_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .pwr_mode(pwr_mode),
    .ext_irq(ext_irq), .ext_sfi(ext_sfi), .nmi(nmi), .periph_irq(periph_irq),
    .ovr_evt(ovr_evt), .ack(ack), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_valid(irq_valid),
    .irq_idx(irq_idx), .wake(wake), .wake_isr(wake_isr));

  always #10 clk = ~clk;

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(a, d);
    chk(req, $sformatf("reg %0d", a), {24'd0, d}, {24'd0, exp});
  endtask

  task automatic clr_all();
    for (int a = 0; a < 6; a++) wr(3'(a), 8'h00);
  endtask

  task automatic pulse_per(input logic [10:0] v);
    periph_irq = v; tick(1); periph_irq = '0; tick(1);
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) rd_chk("R1", 3'(a), 8'h00);
    chk("R1", "irq_valid", {31'd0, irq_valid}, 0);
    chk("R1", "wake", {30'd0, wake, wake_isr}, 0);
  endtask

  task automatic t_regs();
    wr(3'd2, 8'hA5); rd_chk("R4", 3'd2, 8'hA5);
    wr(3'd3, 8'h3C); rd_chk("R4", 3'd3, 8'h3C);
    wr(3'd5, 8'hFF); rd_chk("R4", 3'd5, 8'h0F);
    rd_chk("R4", 3'd6, 8'h00);
    clr_all();
  endtask

  task automatic t_ext_strobe();
    sample_en = 1'b0; ext_irq = 4'b0001; tick(1);
    ext_irq = '0; sample_en = 1'b1; tick(2);
    rd_chk("R2", 3'd1, 8'h00);   // pulse missed without strobe
    ext_irq = 4'b0010; tick(1);
    rd_chk("R2", 3'd1, 8'h20);   // bit 13
    ext_irq = '0; tick(1);
    clr_all();
    pwr_mode = 2'd2; sample_en = 1'b0; ext_irq = 4'b0100; tick(1);
    rd_chk("R2", 3'd1, 8'h40);   // standby samples every cycle
    ext_irq = '0; tick(1);
    pwr_mode = 2'd0; sample_en = 1'b1;
    clr_all();
  endtask

  task automatic t_prio();
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF);
    pulse_per(11'b000_0001_0001);       // bits 1 and 5
    rd_chk("R3", 3'd0, 8'h22);
    chk("R6", "valid", {31'd0, irq_valid}, 1);
    chk("R6", "idx high", {27'd0, irq_idx}, 5);
    wr(3'd2, 8'hDF); tick(1);
    chk("R6", "idx after mask", {27'd0, irq_idx}, 1);
    ext_irq = 4'b0100; tick(1); ext_irq = '0; tick(1);
    chk("R6", "idx ext", {27'd0, irq_idx}, 14);
    wr(3'd2, 8'h00); wr(3'd3, 8'h00); tick(1);
    chk("R6", "all masked", {31'd0, irq_valid}, 0);
    clr_all();
  endtask

  task automatic t_nmi();
    wr(3'd2, 8'hFF);
    pulse_per(11'b000_0000_0001);       // bit 1
    chk("R6", "pre nmi idx", {27'd0, irq_idx}, 1);
    nmi = 1'b1; tick(1); nmi = 1'b0;
    chk("R5", "nmi idx", {27'd0, irq_idx}, 31);
    wr(3'd2, 8'h00); tick(1);
    chk("R5", "nmi unmaskable", {26'd0, irq_valid, irq_idx}, {26'd0, 1'b1, 5'd31});
    wr(3'd2, 8'hFF);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7", "after nmi ack", {27'd0, irq_idx}, 1);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7", "empty", {31'd0, irq_valid}, 0);
    clr_all();
  endtask

  task automatic t_ack();
    wr(3'd2, 8'hFF);
    pulse_per(11'b000_0000_0110);       // bits 2 and 3
    chk("R7", "first", {27'd0, irq_idx}, 3);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7", "second", {27'd0, irq_idx}, 2);
    rd_chk("R7", 3'd0, 8'h04);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk("R7", "drained", {31'd0, irq_valid}, 0);
    clr_all();
  endtask

  task automatic t_hw_wins();
    pulse_per(11'b000_0000_0010);       // bit 2
    rd_chk("R8", 3'd0, 8'h04);
    periph_irq = 11'b000_0000_0001;
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h00;
    tick(1);
    reg_wr = 1'b0; periph_irq = '0;
    rd_chk("R8", 3'd0, 8'h02);
    tick(1);
    clr_all();
  endtask

  task automatic t_ovr();
    wr(3'd5, 8'h01);
    ovr_evt = 4'b0010; tick(1); ovr_evt = '0; tick(3);
    rd_chk("R3", 3'd4, 8'h02);
    rd_chk("R3", 3'd0, 8'h00);
    ovr_evt = 4'b0001; tick(1); ovr_evt = '0; tick(3);
    rd_chk("R3", 3'd4, 8'h03);
    rd_chk("R3", 3'd0, 8'h01);
    clr_all();
  endtask

  task automatic t_wake_sb();
    pwr_mode = 2'd2; ext_sfi = 4'b0001;
    ext_irq = 4'b0010; tick(3);
    chk("R9", "unconfigured pin", {30'd0, wake, wake_isr}, 0);
    ext_irq = 4'b0011; tick(3);
    chk("R9", "masked wake", {30'd0, wake, wake_isr}, 2'b10);
    wr(3'd3, 8'h10); tick(2);
    chk("R9", "enabled wake", {30'd0, wake, wake_isr}, 2'b11);
    pwr_mode = 2'd3; tick(2);
    chk("R9", "powerdown wake", {30'd0, wake, wake_isr}, 2'b11);
    ext_irq = '0; pwr_mode = 2'd0; ext_sfi = '0; tick(2);
    clr_all();
  endtask

  task automatic t_wake_idle();
    pwr_mode = 2'd1;
    wr(3'd2, 8'h08);
    pulse_per(11'b000_0000_1000);       // bit 4, masked off
    tick(2);
    chk("R10", "masked no wake", {30'd0, wake, wake_isr}, 0);
    pulse_per(11'b000_0000_0100);       // bit 3, enabled
    tick(1);
    chk("R10", "idle wake", {30'd0, wake, wake_isr}, 2'b11);
    pwr_mode = 2'd0; tick(2);
    chk("R11", "run quiet", {30'd0, wake, wake_isr}, 0);
    clr_all();
  endtask

  initial begin
    rst_n = 1'b0; sample_en = 1'b1; pwr_mode = 2'd0; ext_irq = '0; ext_sfi = '0;
    nmi = 1'b0; periph_irq = '0; ovr_evt = '0; ack = 1'b0; reg_wr = 1'b0;
    reg_addr = '0; reg_wdata = '0;
    tick(3);
    rst_n = 1'b1;
    tick(2);
    t_reset();
    t_regs();
    t_ext_strobe();
    t_prio();
    t_nmi();
    t_ack();
    t_hw_wins();
    t_ovr();
    t_wake_sb();
    t_wake_idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      vectors++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule